// File: doc/BRIEF.md
# Alternating-Polarity Ripple Carry Adder

This block adds two unsigned operands of a configurable, even width together with a one-bit carry-in. It returns a sum of the same width and a carry-out. It is built from a chain of gate-level full-adder stages that come in two kinds and take turns. Even-numbered stages form their carry with an AND-OR-INVERT function and pass it on complemented. Odd-numbered stages take that complemented carry, form their carry with an OR-AND-INVERT function, and pass it on in true form.

Because of this, no inverter sits anywhere on the carry path. Each stage gets its sum bit from the XOR of its propagate term and its incoming carry. In stages whose carry arrives complemented, an XNOR restores the true sum.

The datapath is purely combinational, with no clock and no registers. It is meant as a small, regular two-operand building block, for example as the node of a larger summation tree.

Top module: `alt_ripple_adder`

## Requirements
- R1: For every a_i, b_i and cin_i, the value {cout_o, sum_o} equals a_i + b_i + cin_i, taken as an unsigned number of WIDTH+1 bits.
- R2: cin_i adds exactly one to the result. With the same operands, the result for cin_i=1 is one more, modulo 2^(WIDTH+1), than the result for cin_i=0.
- R3: All-zero operands with cin_i=0 give sum_o=0 and cout_o=0.
- R4: All-ones operands with cin_i=1 give sum_o all ones and cout_o=1.
- R5: A carry injected at bit 0 travels through every stage. With a_i all ones, b_i=0 and cin_i=1, the result is sum_o=0 and cout_o=1. The same holds for a_i=1010...10, b_i=0101...01 and cin_i=1.
- R6: The largest operands with cin_i=0 give sum_o = 2^WIDTH-2 (all ones except bit 0) and cout_o=1.
- R7: WIDTH is a parameter, and the block is correct at 8, 16 and 32 bits. An odd WIDTH is rejected at elaboration.
- R8: Outputs follow the inputs with no clock: a new input value is reflected at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Low WIDTH bits of the result |
| cout_o | output | 1 | Carry out of the top stage (true polarity) |

## Verification
The hardest behaviour to provoke from the ports is a carry that enters at bit 0 and must cross every stage, and therefore both carry polarities, before it reaches cout_o. Random operands almost never produce a full-length propagate run. The stimulus therefore forces it directly: all-ones against zero, and alternating 1010/0101 patterns, each with carry-in set. Maximum operands are also applied with and without carry-in. The same corner patterns are repeated at 8 and 32 bits, so that the boundary between stage kinds is exercised at every width.

// File: rtl/ara_pkg.sv
package ara_pkg;
  typedef enum logic {STAGE_AOI = 1'b0, STAGE_OAI = 1'b1} stage_kind_e;

  // Stage kind follows bit index: even -> AOI (true carry in), odd -> OAI
  function automatic stage_kind_e kind_of(input int idx);
    return (idx % 2 == 0) ? STAGE_AOI : STAGE_OAI;
  endfunction
endpackage

// File: rtl/ara_pg_cell.sv
module ara_pg_cell (
  input  logic a_i,
  input  logic b_i,
  output logic gen_o,
  output logic prop_o
);
  assign gen_o  = a_i & b_i;
  assign prop_o = a_i ^ b_i;
endmodule

// File: rtl/ara_aoi_stage.sv
module ara_aoi_stage (
  input  logic gen_i,
  input  logic prop_i,
  input  logic carry_i,    // true polarity
  output logic carry_n_o,  // complemented polarity
  output logic sum_o
);
  assign carry_n_o = ~(gen_i | (prop_i & carry_i));
  assign sum_o     = prop_i ^ carry_i;
endmodule

// File: rtl/ara_oai_stage.sv
module ara_oai_stage (
  input  logic gen_i,
  input  logic prop_i,
  input  logic carry_n_i,  // complemented polarity
  output logic carry_o,    // true polarity
  output logic sum_o
);
  logic gen_n;
  logic prop_n;

  // Operand-side inversions, off the carry path
  assign gen_n   = ~gen_i;
  assign prop_n  = ~prop_i;
  assign carry_o = ~((prop_n | carry_n_i) & gen_n);
  // Incoming carry is complemented, so XNOR restores the true sum
  assign sum_o   = ~(prop_i ^ carry_n_i);
endmodule

// File: rtl/alt_ripple_adder.sv
module alt_ripple_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  import ara_pkg::*;

  localparam int NUM_PAIRS = WIDTH / 2;

  // chain[k] is the carry into stage k; even k true, odd k complemented
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;

  if ((WIDTH % 2) != 0 || NUM_PAIRS < 1) begin : g_bad_width
    $error("alt_ripple_adder: WIDTH must be a positive even number");
  end

  assign chain[0] = cin_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    ara_pg_cell u_pg (
      .a_i   (a_i[k]),
      .b_i   (b_i[k]),
      .gen_o (gen[k]),
      .prop_o(prop[k])
    );

    if (kind_of(k) == STAGE_AOI) begin : g_aoi
      ara_aoi_stage u_cell (
        .gen_i    (gen[k]),
        .prop_i   (prop[k]),
        .carry_i  (chain[k]),
        .carry_n_o(chain[k+1]),
        .sum_o    (sum_o[k])
      );
    end else begin : g_oai
      ara_oai_stage u_cell (
        .gen_i    (gen[k]),
        .prop_i   (prop[k]),
        .carry_n_i(chain[k]),
        .carry_o  (chain[k+1]),
        .sum_o    (sum_o[k])
      );
    end
  end

  // Top stage is OAI for even WIDTH, so the final carry is true polarity
  assign cout_o = chain[WIDTH];
endmodule

// File: rtl/alt_ripple_adder_chk.sv
module alt_ripple_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    assert_sum_exact_R1: assert ({cout_o, sum_o} == ref_sum)
      else $error("R1 sum mismatch");
    if (a_i == ZERO && b_i == ZERO && !cin_i)
      assert_zero_in_R3: assert (sum_o == ZERO && !cout_o)
        else $error("R3 zero case");
    if (a_i == ONES && b_i == ONES && cin_i)
      assert_all_ones_R4: assert (sum_o == ONES && cout_o)
        else $error("R4 all ones case");
    if (a_i == ONES && b_i == ZERO && cin_i)
      assert_full_ripple_R5: assert (sum_o == ZERO && cout_o)
        else $error("R5 full ripple case");
    if (a_i == ONES && b_i == ONES && !cin_i)
      assert_max_ops_R6: assert (sum_o == (ONES - 1'b1) && cout_o)
        else $error("R6 max operand case");
  end
endmodule

bind alt_ripple_adder alt_ripple_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .cin_i (cin_i),
  .sum_o (sum_o),
  .cout_o(cout_o)
);

// File: tb/test_alt_ripple_adder.sv
module test_alt_ripple_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] exp_sum;
    logic         exp_cout;
    string        tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [W-1:0] a_s = '0, b_s = '0;
  logic         cin_s = 1'b0;
  logic [W-1:0] sum_s;
  logic         cout_s;

  alt_ripple_adder #(.WIDTH(W)) i_alt_ripple_adder (
    .a_i(a_s), .b_i(b_s), .cin_i(cin_s), .sum_o(sum_s), .cout_o(cout_s)
  );

  logic [7:0]  a8 = '0, b8 = '0, s8;
  logic        c8 = 1'b0, co8;
  logic [31:0] a32 = '0, b32 = '0, s32;
  logic        c32 = 1'b0, co32;

  alt_ripple_adder #(.WIDTH(8)) i_alt_ripple_adder_w8 (
    .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8)
  );
  alt_ripple_adder #(.WIDTH(32)) i_alt_ripple_adder_w32 (
    .a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32), .cout_o(co32)
  );

  sb_item_t sb[$];

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input string tag);
    logic [W:0] e;
    sb_item_t it;
    @(posedge clk);
    a_s = a; b_s = b; cin_s = c;
    e = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    it.exp_sum = e[W-1:0]; it.exp_cout = e[W]; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares half a period after each drive
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      checks++;
      if (sum_s !== it.exp_sum || cout_s !== it.exp_cout) begin
        errors++;
        $display("FAIL %s: got cout=%0b sum=%h, expected cout=%0b sum=%h",
                 it.tag, cout_s, sum_s, it.exp_cout, it.exp_sum);
      end
    end
  end

  task automatic chk8(input logic [7:0] a, input logic [7:0] b, input logic c,
                      input string tag);
    logic [8:0] e;
    a8 = a; b8 = b; c8 = c;
    #1;
    e = {1'b0, a} + {1'b0, b} + {8'd0, c};
    checks++;
    if ({co8, s8} !== e) begin
      errors++;
      $display("FAIL %s: got %h, expected %h", tag, {co8, s8}, e);
    end
  endtask

  task automatic chk32(input logic [31:0] a, input logic [31:0] b, input logic c,
                       input string tag);
    logic [32:0] e;
    a32 = a; b32 = b; c32 = c;
    #1;
    e = {1'b0, a} + {1'b0, b} + {32'd0, c};
    checks++;
    if ({co32, s32} !== e) begin
      errors++;
      $display("FAIL %s: got %h, expected %h", tag, {co32, s32}, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R3: zero inputs give zero result, observed during reset
    if (sum_s !== '0 || cout_s !== 1'b0) begin
      errors++;
      $display("FAIL R3 reset-time zero: got %0b/%h, expected 0/0", cout_s, sum_s);
    end
    rst_n = 1'b1;

    drive('0, '0, 1'b0, "R3 zeros");
    drive(16'h1234, 16'h0F0F, 1'b0, "R2 cin=0");
    drive(16'h1234, 16'h0F0F, 1'b1, "R2 cin=1");
    drive('1, '1, 1'b1, "R4 all ones");
    drive('1, '0, 1'b1, "R5 ripple ones+0");
    drive(16'hAAAA, 16'h5555, 1'b1, "R5 ripple alternating");
    drive('0, '1, 1'b1, "R5 ripple 0+ones");
    drive('1, '1, 1'b0, "R6 max operands");
    drive(16'h8000, 16'h8000, 1'b0, "R1 top carry only");
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[15:0], r[31:16], r[0] ^ r[17], "R1 random");
    end
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);

    // R7 and R8: other widths, checked one time step after each change, no clock
    chk8(8'h00, 8'h00, 1'b0, "R7 w8 zeros");
    chk8(8'hFF, 8'h00, 1'b1, "R7 R8 w8 full ripple");
    chk8(8'hFF, 8'hFF, 1'b0, "R7 w8 max");
    chk8(8'hFF, 8'hFF, 1'b1, "R7 w8 all ones");
    chk32('1, '0, 1'b1, "R7 R8 w32 full ripple");
    chk32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R7 w32 alternating");
    chk32('1, '1, 1'b0, "R7 w32 max");
    for (int n = 0; n < 50; n++) begin
      chk8($urandom, $urandom, $urandom, "R7 w8 random");
      chk32($urandom, $urandom, $urandom, "R7 w32 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule